// File: doc/BRIEF.md
# SIMD Integer Lane ALU with Instruction Decode

This block takes one 32-bit vector instruction word together with two 128-bit source vectors and produces a 128-bit result. The instruction word is decoded on the spot. Its prefix bits, size field and opcode field together choose four things: the operation, the lane width (8, 16, 32 or 64 bits), whether a compare is signed or unsigned, and whether the encoding is supported at all. The supported operations are lane-wise add, subtract, low-half multiply, equality compare, unsigned greater-than and signed greater-than. A byte table lookup is also supported, in which the second vector indexes the bytes of the first.

The surrounding pipeline presents `insn`, `vec_n` and `vec_m` with `in_valid` high for one cycle. One clock edge later the block shows the result, a valid pulse and an illegal-instruction flag. The three register-number fields of the word are carried for the caller's benefit only, because the operands arrive already read.

Top module: `simd_lane_alu`

## Requirements
- R1: A lane operation needs `insn[28:24]` = 01110 and `insn[21]` = 1. The lane width comes from `insn[23:22]`: 00 gives 8 bits, 01 gives 16, 10 gives 32 and 11 gives 64. The register fields `insn[20:16]`, `insn[9:5]` and `insn[4:0]` do not affect the result.
- R2: Prefix `insn[31:29]` = 010 with opcode `insn[15:10]` = 100001 adds each lane of `vec_n` and `vec_m` modulo the lane width. It is legal at every width.
- R3: Prefix 011 with opcode 100001 subtracts each lane of `vec_m` from the matching lane of `vec_n`, modulo the lane width. It is legal at every width.
- R4: Prefix 010 with opcode 100111 multiplies lanes and keeps the low lane-width bits of each product. It is legal at 8, 16 and 32 bits. Size 11 is illegal.
- R5: Prefix 011 with opcode 100011 writes all ones to a lane whose two operands are equal, and all zeros to any other lane. It is legal at every width.
- R6: Opcode 001101 with prefix 011 sets a lane to all ones when the `vec_n` lane is greater than the `vec_m` lane as an unsigned number, and to zero otherwise.
- R7: Opcode 001101 with prefix 010 does the same comparison with both lanes taken as two's-complement signed numbers.
- R8: The word with prefix 010, `insn[28:21]` = 01110000 and opcode 000000 is a table lookup. Result byte i is byte k of `vec_n`, where k is byte i of `vec_m`. When k is 16 or more, result byte i is 0.
- R9: Every other encoding sets `out_illegal` and makes `result` zero.
- R10: `result`, `out_valid` and `out_illegal` are registered and appear on the clock edge that samples `in_valid` high. `out_valid` is high for exactly that one cycle. While `in_valid` is low, `result` and `out_illegal` keep their values.
- R11: After reset, `result` is zero and `out_valid` and `out_illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands are present |
| insn | input | 32 | Instruction word |
| vec_n | input | 128 | First source vector (table for lookup) |
| vec_m | input | 128 | Second source vector (indices for lookup) |
| result | output | 128 | Registered result |
| out_valid | output | 1 | Result valid, one cycle after `in_valid` |
| out_illegal | output | 1 | Instruction was not a supported encoding |

## Verification
On every cycle the assertions check four things: the one-cycle valid pulse, that the result and flag hold while idle, that the result is zero whenever the flag is set, and that a 64-bit multiply is always rejected. They also check that a 64-bit equality compare yields uniform lanes and returns all ones for identical operands. Whether lane boundaries stop carries and borrows, how signed and unsigned ordering differ, and what the table lookup does with out-of-range indices can only be shown by the bench. Its scenarios compare each operation at each width against a lane model it computes itself.

// File: rtl/simd_lane_alu.sv
module simd_lane_alu (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [31:0]  insn,
  input  logic [127:0] vec_n,
  input  logic [127:0] vec_m,
  output logic [127:0] result,
  output logic         out_valid,
  output logic         out_illegal
);
  localparam int VW = 128;
  localparam int NB = VW / 8;

  wire [2:0] pfx  = insn[31:29];
  wire [4:0] grp  = insn[28:24];
  wire [1:0] sz   = insn[23:22];
  wire       b21  = insn[21];
  wire [5:0] opc  = insn[15:10];

  wire lane_grp = (grp == 5'b01110) && b21;
  wire is_add = lane_grp && pfx == 3'b010 && opc == 6'b100001;
  wire is_sub = lane_grp && pfx == 3'b011 && opc == 6'b100001;
  wire is_mul = lane_grp && pfx == 3'b010 && opc == 6'b100111 && sz != 2'b11;
  wire is_eq  = lane_grp && pfx == 3'b011 && opc == 6'b100011;
  wire is_hi  = lane_grp && pfx == 3'b011 && opc == 6'b001101;
  wire is_gt  = lane_grp && pfx == 3'b010 && opc == 6'b001101;
  wire is_tbl = grp == 5'b01110 && sz == 2'b00 && !b21 && pfx == 3'b010 && opc == 6'b000000;
  wire legal  = is_add | is_sub | is_mul | is_eq | is_hi | is_gt | is_tbl;

  logic [VW-1:0] r_add [4];
  logic [VW-1:0] r_sub [4];
  logic [VW-1:0] r_mul [4];
  logic [VW-1:0] r_eq  [4];
  logic [VW-1:0] r_hi  [4];
  logic [VW-1:0] r_gt  [4];
  logic [VW-1:0] r_tbl;

  for (genvar g = 0; g < 4; g++) begin : g_width
    localparam int LW = 8 << g;
    localparam int NL = VW / LW;
    for (genvar l = 0; l < NL; l++) begin : g_lane
      wire [LW-1:0] x = vec_n[l*LW +: LW];
      wire [LW-1:0] y = vec_m[l*LW +: LW];
      assign r_add[g][l*LW +: LW] = x + y;
      assign r_sub[g][l*LW +: LW] = x - y;
      assign r_eq[g][l*LW +: LW]  = {LW{x == y}};
      assign r_hi[g][l*LW +: LW]  = {LW{x > y}};
      assign r_gt[g][l*LW +: LW]  = {LW{$signed(x) > $signed(y)}};
      if (g < 3) begin : g_mul
        assign r_mul[g][l*LW +: LW] = x * y;
      end else begin : g_nomul
        assign r_mul[g][l*LW +: LW] = '0;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_tbl
    wire [7:0] idx = vec_m[b*8 +: 8];
    assign r_tbl[b*8 +: 8] = (idx < 8'(NB)) ? vec_n[idx[3:0]*8 +: 8] : 8'h00;
  end

  logic [VW-1:0] nxt;
  always_comb begin
    nxt = '0;
    if (is_add)      nxt = r_add[sz];
    else if (is_sub) nxt = r_sub[sz];
    else if (is_mul) nxt = r_mul[sz];
    else if (is_eq)  nxt = r_eq[sz];
    else if (is_hi)  nxt = r_hi[sz];
    else if (is_gt)  nxt = r_gt[sz];
    else if (is_tbl) nxt = r_tbl;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result      <= '0;
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result      <= nxt;
        out_illegal <= !legal;
      end
    end
  end
endmodule

module simd_lane_alu_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic [31:0]  insn,
  input logic [127:0] vec_n,
  input logic [127:0] vec_m,
  input logic [127:0] result,
  input logic         out_valid,
  input logic         out_illegal
);
  wire mul64 = insn[31:29] == 3'b010 && insn[28:21] == 8'b01110111 && insn[15:10] == 6'b100111;
  wire eq64  = insn[31:29] == 3'b011 && insn[28:21] == 8'b01110111 && insn[15:10] == 6'b100011;

  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(result) && $stable(out_illegal));
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> result == '0);
  a_r4_mul64_illegal: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mul64 |=> out_illegal);
  a_r5_eq_uniform: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && eq64 |=> (result[63:0] == '0 || result[63:0] == '1) &&
                         (result[127:64] == '0 || result[127:64] == '1));
  a_r5_eq_self: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && eq64 && vec_n == vec_m |=> result == '1);
endmodule

bind simd_lane_alu simd_lane_alu_chk u_chk (.*);

// File: tb/simd_lane_alu_bench.sv
module simd_lane_alu_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [31:0]  insn = '0;
  logic [127:0] vec_n = '0;
  logic [127:0] vec_m = '0;
  logic [127:0] result;
  logic         out_valid;
  logic         out_illegal;
  int checks = 0;
  int errors = 0;

  simd_lane_alu u_simd_lane_alu (.*);

  always #5 clk = ~clk;

  localparam logic [127:0] PA = 128'h0123456789abcdef_fedcba9876543210;
  localparam logic [127:0] PB = 128'hffffffff00000001_80000000800000ff;
  localparam logic [127:0] PC = 128'h7fff8000ffff0001_0123456789abcdef;

  function automatic logic [31:0] mk(input logic [2:0] p, input logic [1:0] s,
                                     input logic b, input logic [5:0] o);
    return {p, 5'b01110, s, b, 5'd7, o, 5'd3, 5'd9};
  endfunction

  function automatic logic [127:0] model(input int kind, input int s,
                                         input logic [127:0] a, input logic [127:0] b);
    int w = 8 << s;
    logic [63:0] mask = (w == 64) ? '1 : ((64'd1 << w) - 1);
    logic [63:0] sb = 64'd1 << (w - 1);
    logic [127:0] r = '0;
    for (int l = 0; l < 128 / w; l++) begin
      logic [63:0] x = 64'(a >> (l * w)) & mask;
      logic [63:0] y = 64'(b >> (l * w)) & mask;
      logic [63:0] z;
      case (kind)
        0: z = x + y;
        1: z = x - y;
        2: z = x * y;
        3: z = (x == y) ? '1 : '0;
        4: z = (x > y) ? '1 : '0;
        default: z = ((x ^ sb) > (y ^ sb)) ? '1 : '0;
      endcase
      r = r | ({64'd0, z & mask} << (l * w));
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b);
    @(negedge clk);
    insn = w; vec_n = a; vec_m = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_op(input string req, input int kind, input logic [2:0] p,
                        input logic [5:0] o, input int s,
                        input logic [127:0] a, input logic [127:0] b);
    issue(mk(p, 2'(s), 1'b1, o), a, b);
    chk(req, result, model(kind, s, a, b));
    chk({req, " flag"}, {126'd0, out_valid, out_illegal}, 128'd2);
  endtask

  task automatic t_reset;
    chk("R11 reset", {result[127:2], out_valid, out_illegal}, '0);
    chk("R11 reset result", result, '0);
  endtask

  task automatic t_arith;
    for (int s = 0; s < 4; s++) begin
      run_op("R2 add", 0, 3'b010, 6'b100001, s, PA, PB);
      run_op("R2 add wrap", 0, 3'b010, 6'b100001, s, '1, 128'h1 | (128'h1 << 64));
      run_op("R3 sub", 1, 3'b011, 6'b100001, s, PB, PA);
      run_op("R3 sub borrow", 1, 3'b011, 6'b100001, s, '0, PC);
    end
    for (int s = 0; s < 3; s++) begin
      run_op("R4 mul", 2, 3'b010, 6'b100111, s, PA, PC);
      run_op("R4 mul max", 2, 3'b010, 6'b100111, s, '1, '1);
    end
  endtask

  task automatic t_compare;
    logic [127:0] half = {PA[127:64], PB[63:0]};
    for (int s = 0; s < 4; s++) begin
      run_op("R5 eq", 3, 3'b011, 6'b100011, s, PA, half);
      run_op("R6 hi", 4, 3'b011, 6'b001101, s, PA, PC);
      run_op("R6 hi rev", 4, 3'b011, 6'b001101, s, PC, PA);
      run_op("R7 gt", 5, 3'b010, 6'b001101, s, PA, PC);
      run_op("R7 gt rev", 5, 3'b010, 6'b001101, s, PB, PA);
    end
    issue(mk(3'b011, 2'b00, 1'b1, 6'b001101), {16{8'h80}}, {16{8'h7f}});
    chk("R6 hi 80>7f", result, '1);
    issue(mk(3'b010, 2'b00, 1'b1, 6'b001101), {16{8'h80}}, {16{8'h7f}});
    chk("R7 gt 80<7f", result, '0);
  endtask

  task automatic t_table;
    logic [127:0] tab = 128'h0f0e0d0c0b0a09080706050403020100 ^ {16{8'hA0}};
    logic [127:0] idx = 128'h00_01_0f_10_ff_07_08_20_03_03_0e_11_05_0c_80_02;
    logic [127:0] exp = '0;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] k = idx[i*8 +: 8];
      if (k < 16) exp[i*8 +: 8] = tab[k*8 +: 8];
    end
    issue({3'b010, 8'b01110000, 5'd4, 6'b000000, 5'd5, 5'd6}, tab, idx);
    chk("R8 table", result, exp);
    chk("R8 table legal", {127'd0, out_illegal}, '0);
  endtask

  task automatic t_illegal;
    issue(mk(3'b010, 2'b11, 1'b1, 6'b100111), PA, PC);
    chk("R4 mul64 illegal", {result[127:1], out_illegal}, 128'd1);
    issue({3'b010, 5'b01111, 2'b10, 1'b1, 5'd0, 6'b100001, 10'd0}, PA, PB);
    chk("R1 R9 bad group", {result[127:1], out_illegal}, 128'd1);
    issue(mk(3'b010, 2'b01, 1'b0, 6'b100001), PA, PB);
    chk("R1 R9 bit21 clear", {result[127:1], out_illegal}, 128'd1);
    issue({3'b011, 8'b01110000, 5'd0, 6'b000000, 10'd0}, PA, PB);
    chk("R9 table prefix", {result[127:1], out_illegal}, 128'd1);
    issue(mk(3'b010, 2'b00, 1'b1, 6'b100011), PA, PA);
    chk("R9 eq prefix", {result[127:1], out_illegal}, 128'd1);
    issue(mk(3'b001, 2'b00, 1'b1, 6'b100001), PA, PB);
    chk("R9 prefix 001", {result[127:1], out_illegal}, 128'd1);
  endtask

  task automatic t_regfields;
    logic [127:0] r0;
    issue(mk(3'b010, 2'b10, 1'b1, 6'b100001), PA, PC);
    r0 = result;
    issue({3'b010, 8'b01110101, 5'd31, 6'b100001, 5'd0, 5'd17}, PA, PC);
    chk("R1 reg fields ignored", result, r0);
  endtask

  task automatic t_hold;
    logic [127:0] exp = model(0, 1, PA, PC);
    issue(mk(3'b010, 2'b01, 1'b1, 6'b100001), PA, PC);
    @(negedge clk);
    insn = mk(3'b001, 2'b00, 1'b0, 6'd0); vec_n = PB; vec_m = PB;
    @(negedge clk);
    @(negedge clk);
    chk("R10 hold result", result, exp);
    chk("R10 idle flags", {126'd0, out_valid, out_illegal}, '0);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_arith();
    t_compare();
    t_table();
    t_illegal();
    t_regfields();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule